// File: doc/BRIEF.md
# Speech Interpolating Band-Limit Filter

This block raises the sample rate of a 16-bit signed speech stream by a fixed factor of five, from 8 kHz to 40 kHz, and shapes the result so that it can feed an over-sampling converter. Each accepted input sample becomes five output samples. Zeros fill the four new slots, and a symmetric low-pass FIR then smooths the stream. A first-order DC-blocking high-pass stage runs on the 40 kHz stream after the FIR. The final result saturates to 16 bits.

Everything runs from one fast system clock. The input side is a valid/ready handshake that takes one sample every input period. The output side gives a single-cycle strobe every `OUT_DIV` clocks, five times per accepted sample. A bypass control is sampled with each input sample. When it is set, that sample is repeated five times unchanged, which is a zero-order hold. Bypass also clears the filter history, so that filtering restarts from rest.

Top module: `speech_interp_filter`

## Requirements
- R1: A synchronous reset leaves `out_valid` low and `in_ready` high from the next clock. It also empties every delay line, so the first filtered output depends only on the first sample.
- R2: `in_ready` is high only while no sample is being expanded. It goes low in the cycle after an accepting edge, where `in_valid` and `in_ready` are both high. An `in_valid` held high while `in_ready` is low is not taken.
- R3: Each accepted sample yields exactly five `out_valid` strobes, each one cycle wide. The first is visible two clocks after the accepting edge, and the rest follow at a spacing of `OUT_DIV` clocks.
- R4: In filter mode, the five-fold stream holds the input sample in the first slot and zeros in the other four. It passes through a 9-tap FIR with weights 3, 6, 10, 13, 16, 13, 10, 6, 3, and the sum is shifted right arithmetically by 4. Each of the five polyphase branches therefore has unity gain.
- R5: The FIR result f feeds y[n] = f[n] − f[n−1] + y[n−1] − (y[n−1] >>> 6). The arithmetic is 24-bit, and state advances once per output strobe.
- R6: The output saturates to the range −32768 to +32767 and never wraps.
- R7: When the bypass input is high at the accepting edge, all five outputs for that sample equal the input sample. A later change of bypass does not affect that sample.
- R8: A bypassed sample clears the FIR and high-pass history. The next filtered sample is processed as if it came straight after reset.
- R9: A constant input in filter mode decays toward zero at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | 16 | Signed input speech sample |
| bypass | input | 1 | Hold-only mode for the offered sample |
| out_valid | output | 1 | One-cycle strobe for a 40 kHz output sample |
| out_sample | output | 16 | Signed, saturated output sample |

## Verification
An impulse followed by zeros shows the FIR weights one by one. A long constant run separates a working DC blocker from a pass-through and confirms that the polyphase gains are flat. A full-scale swing from negative to positive drives the high-pass past 16 bits, which shows whether the output saturates or wraps. A bypassed sample, with bypass toggled while that sample is being expanded and followed by filtered samples, shows both that bypass is latched at the accepting edge and that history is cleared. Random samples with random gaps, random early `in_valid` and occasional bypass then check values and strobe timing against a bench model.

// File: rtl/sif_pkg.sv
package sif_pkg;

    parameter int DATA_W     = 16;
    parameter int ACC_W      = 24;
    parameter int UP         = 5;
    parameter int TAPS       = 9;
    parameter int COEF_SHIFT = 4;
    parameter int POLE_SHIFT = 6;

    typedef struct packed {
        logic                     vld;
        logic                     first;
        logic                     byp;
        logic signed [DATA_W-1:0] smp;
    } tick_t;

    // symmetric low-pass weights; every polyphase branch sums to 2**COEF_SHIFT
    function automatic int lp_coef(input int k);
        int m;
        m = (k > (TAPS - 1) / 2) ? (TAPS - 1 - k) : k;
        case (m)
            0:       return 3;
            1:       return 6;
            2:       return 10;
            3:       return 13;
            default: return 16;
        endcase
    endfunction

    function automatic logic signed [DATA_W-1:0] clamp_data(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] hi;
        logic signed [ACC_W-1:0] lo;
        hi = ACC_W'((2 ** (DATA_W - 1)) - 1);
        lo = -ACC_W'(2 ** (DATA_W - 1));
        if (v > hi)      return DATA_W'(hi);
        else if (v < lo) return DATA_W'(lo);
        else             return DATA_W'(v);
    endfunction

endpackage

// File: rtl/sif_phase_ctrl.sv
module sif_phase_ctrl
    import sif_pkg::*;
#(
    parameter int OUT_DIV = 2500
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     bypass,
    output logic                     in_ready,
    output tick_t                    tick
);
    localparam int TW = (OUT_DIV > 1) ? $clog2(OUT_DIV) : 1;
    localparam int PW = $clog2(UP + 1);
    localparam logic [TW-1:0] TLAST = TW'(OUT_DIV - 1);
    localparam logic [PW-1:0] PLAST = PW'(UP - 1);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] phase;
        logic [TW-1:0] timer;
        tick_t         tk;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.tk.vld = 1'b0;
        if (!st_q.busy) begin
            if (in_valid) begin
                st_d.busy     = 1'b1;
                st_d.phase    = '0;
                st_d.timer    = '0;
                st_d.tk.vld   = 1'b1;
                st_d.tk.first = 1'b1;
                st_d.tk.byp   = bypass;
                st_d.tk.smp   = in_sample;
            end
        end else if (st_q.timer == TLAST) begin
            st_d.timer = '0;
            if (st_q.phase == PLAST) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.phase    = st_q.phase + 1'b1;
                st_d.tk.vld   = 1'b1;
                st_d.tk.first = 1'b0;
            end
        end else begin
            st_d.timer = st_q.timer + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign in_ready = !st_q.busy;
    assign tick     = st_q.tk;

endmodule

// File: rtl/sif_fir.sv
module sif_fir
    import sif_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  tick_t                   tick,
    output logic                    fir_vld,
    output logic                    fir_byp,
    output logic signed [ACC_W-1:0] fir_val
);
    typedef struct packed {
        logic                    vld;
        logic                    byp;
        logic signed [ACC_W-1:0] val;
    } fout_t;

    logic signed [DATA_W-1:0] dl_d [TAPS];
    logic signed [DATA_W-1:0] dl_q [TAPS];
    logic signed [ACC_W-1:0]  prod [TAPS];
    logic signed [ACC_W-1:0]  acc;
    fout_t                    fo_d, fo_q;

    // next delay-line contents
    always_comb begin
        for (int k = 0; k < TAPS; k++) dl_d[k] = dl_q[k];
        if (tick.vld) begin
            if (tick.byp) begin
                for (int k = 0; k < TAPS; k++) dl_d[k] = '0;
            end else begin
                dl_d[0] = tick.first ? tick.smp : '0;
                for (int k = 1; k < TAPS; k++) dl_d[k] = dl_q[k-1];
            end
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign prod[k] = ACC_W'(signed'(dl_d[k])) * ACC_W'(lp_coef(k));
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
        fo_d     = fo_q;
        fo_d.vld = tick.vld;
        if (tick.vld) begin
            fo_d.byp = tick.byp;
            fo_d.val = tick.byp ? ACC_W'(signed'(tick.smp)) : (acc >>> COEF_SHIFT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAPS; k++) dl_q[k] <= '0;
            fo_q <= '0;
        end else begin
            for (int k = 0; k < TAPS; k++) dl_q[k] <= dl_d[k];
            fo_q <= fo_d;
        end
    end

    assign fir_vld = fo_q.vld;
    assign fir_byp = fo_q.byp;
    assign fir_val = fo_q.val;

endmodule

// File: rtl/sif_hpf.sv
module sif_hpf
    import sif_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fir_vld,
    input  logic                     fir_byp,
    input  logic signed [ACC_W-1:0]  fir_val,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    typedef struct packed {
        logic signed [ACC_W-1:0]  x1;
        logic signed [ACC_W-1:0]  y1;
        logic                     ov;
        logic signed [DATA_W-1:0] os;
    } hp_t;

    hp_t                     hp_d, hp_q;
    logic signed [ACC_W-1:0] y_new;

    // pole at 1 - 2^-POLE_SHIFT by shift and subtract
    assign y_new = fir_val - hp_q.x1 + hp_q.y1 - (hp_q.y1 >>> POLE_SHIFT);

    always_comb begin
        hp_d    = hp_q;
        hp_d.ov = fir_vld;
        if (fir_vld) begin
            if (fir_byp) begin
                hp_d.x1 = '0;
                hp_d.y1 = '0;
                hp_d.os = clamp_data(fir_val);
            end else begin
                hp_d.x1 = fir_val;
                hp_d.y1 = y_new;
                hp_d.os = clamp_data(y_new);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hp_q <= '0;
        else     hp_q <= hp_d;
    end

    assign out_valid  = hp_q.ov;
    assign out_sample = hp_q.os;

endmodule

// File: rtl/speech_interp_filter.sv
module speech_interp_filter
    import sif_pkg::*;
#(
    parameter int OUT_DIV = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic signed [15:0] in_sample,
    input  logic              bypass,
    output logic              out_valid,
    output logic signed [15:0] out_sample
);
    tick_t                   tick;
    logic                    fir_vld;
    logic                    fir_byp;
    logic signed [ACC_W-1:0] fir_val;

    sif_phase_ctrl #(.OUT_DIV(OUT_DIV)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .bypass    (bypass),
        .in_ready  (in_ready),
        .tick      (tick)
    );

    sif_fir u_fir (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .fir_vld (fir_vld),
        .fir_byp (fir_byp),
        .fir_val (fir_val)
    );

    sif_hpf u_hpf (
        .clk        (clk),
        .rst        (rst),
        .fir_vld    (fir_vld),
        .fir_byp    (fir_byp),
        .fir_val    (fir_val),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

endmodule

// File: rtl/sif_checker.sv
module sif_checker (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic signed [15:0] in_sample,
    input logic              bypass,
    input logic              out_valid,
    input logic signed [15:0] out_sample
);
    logic [2:0]        strobes;
    logic              held_byp;
    logic signed [15:0] held_smp;
    logic              take;

    assign take = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobes  <= 3'd5;
            held_byp <= 1'b0;
            held_smp <= '0;
        end else if (take) begin
            strobes  <= 3'd0;
            held_byp <= bypass;
            held_smp <= in_sample;
        end else if (out_valid) begin
            strobes <= strobes + 3'd1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> !in_ready);

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_five_max_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (strobes < 3'd5));

    assert_five_done_R3: assert property (@(posedge clk) disable iff (rst)
        take |-> (strobes == 3'd5));

    assert_hold_value_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && held_byp) |-> (out_sample == held_smp));

endmodule

bind speech_interp_filter sif_checker u_chk (.*);

// File: tb/speech_interp_filter_test.sv
module speech_interp_filter_test;
    localparam int DIV = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic              in_ready;
    logic signed [15:0] in_sample;
    logic              bypass;
    logic              out_valid;
    logic signed [15:0] out_sample;

    always #5 clk = ~clk;

    speech_interp_filter #(.OUT_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .bypass(bypass),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    int     n_checks = 0;
    int     n_fail   = 0;
    longint edge_cnt = 0;
    longint last_out = 0;
    longint exp_v[$];
    longint exp_e[$];
    string  exp_r[$];
    longint dl[9];
    longint hx1, hy1;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    function automatic longint wgt(input int k);
        int m;
        m = (k > 4) ? 8 - k : k;
        case (m)
            0: return 3;
            1: return 6;
            2: return 10;
            3: return 13;
            default: return 16;
        endcase
    endfunction

    function automatic longint clip(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 9; k++) dl[k] = 0;
        hx1 = 0;
        hy1 = 0;
    endtask

    task automatic model_push(input longint s, input bit b, input longint acc_edge, input string req);
        longint f, y, a;
        if (b) model_reset();
        for (int p = 0; p < 5; p++) begin
            if (b) begin
                y = s;
            end else begin
                for (int k = 8; k > 0; k--) dl[k] = dl[k-1];
                dl[0] = (p == 0) ? s : 0;
                a = 0;
                for (int k = 0; k < 9; k++) a += wgt(k) * dl[k];
                f = a >>> 4;
                y = f - hx1 + hy1 - (hy1 >>> 6);
                hx1 = f;
                hy1 = y;
            end
            exp_v.push_back(clip(y));
            exp_e.push_back(acc_edge + 2 + longint'(p) * DIV);
            exp_r.push_back(req);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_v.size() == 0) begin
                check(1'b0, "R3 extra strobe", 1, 0);
            end else begin
                check(longint'(out_sample) == exp_v[0], exp_r[0], out_sample, exp_v[0]);
                check(edge_cnt == exp_e[0], "R3 timing", edge_cnt, exp_e[0]);
                last_out = out_sample;
                void'(exp_v.pop_front());
                void'(exp_e.pop_front());
                void'(exp_r.pop_front());
            end
        end
    end

    task automatic send(input int s, input bit b, input int gap, input bit flip, input string req);
        longint acc_edge;
        repeat (gap) @(negedge clk);
        in_sample = 16'(s);
        bypass    = b;
        in_valid  = 1'b1;
        while (!in_ready) @(negedge clk);
        acc_edge = edge_cnt + 1;
        model_push(longint'(signed'(16'(s))), b, acc_edge, req);
        @(negedge clk);
        in_valid = 1'b0;
        if (flip) bypass = ~b;
        check(in_ready == 1'b0, "R2", in_ready, 0);
    endtask

    task automatic drain();
        int t = 0;
        while (exp_v.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1975));
        rst = 1'b1; in_valid = 1'b0; in_sample = '0; bypass = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

        // R1/R4: impulse right after reset shows the weights
        send(16000, 1'b0, 0, 1'b0, "R4");
        for (int i = 0; i < 3; i++) send(0, 1'b0, 0, 1'b0, "R4");
        drain();

        // R9: long constant run must decay
        for (int i = 0; i < 60; i++) send(10000, 1'b0, 0, 1'b0, "R9");
        drain();
        check(last_out < 1000 && last_out > -1000, "R9 decay", last_out, 0);

        // R6: full swing drives saturation
        for (int i = 0; i < 4; i++) send(-32768, 1'b0, 0, 1'b0, "R6");
        for (int i = 0; i < 4; i++) send(32767, 1'b0, 0, 1'b0, "R6");
        for (int i = 0; i < 4; i++) send(-32768, 1'b0, 0, 1'b0, "R6");
        drain();

        // R7: bypass held, bypass flipped during expansion; R8: history cleared
        send(-1234, 1'b1, 0, 1'b1, "R7");
        send(32767, 1'b1, 2, 1'b1, "R7");
        send(20000, 1'b0, 0, 1'b0, "R8");
        send(0, 1'b0, 0, 1'b0, "R8");
        drain();

        // R5: random mix
        for (int i = 0; i < 300; i++) begin
            int s;
            bit b;
            s = int'($urandom_range(0, 65535)) - 32768;
            b = ($urandom_range(0, 7) == 0);
            send(s, b, int'($urandom_range(0, 3)), $urandom_range(0, 1) == 1, b ? "R7" : "R5");
        end
        drain();
        check(exp_v.size() == 0, "R3 missing strobes", exp_v.size(), 0);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule